// File: doc/BRIEF.md
# Latched Dual Interval Timer

This block holds two 16-bit down-counters that a host reaches through byte-wide registers at indices 4 through 9. The first counter has its own 16-bit reload latch. In the free-running mode it counts down from its loaded value, steps past zero to all-ones, and then reloads from the latch. The second counter is a one-shot: it is loaded by a register write and raises its event once, the first time it counts down to zero after that load.

The block does not own an interrupt flag register. Instead it emits single-cycle set pulses when a counter reaches zero. It also emits clear pulses for the register reads and writes that acknowledge an event, so that a neighbouring flag register can track both timers. The mode of the first timer comes from two auxiliary-control bits. Both counters advance on a clock-enable tick that an internal divider produces from a programmable ratio, so the timer rate can be slowed far below the core clock.

Top module: `dual_interval_timer`

## Requirements
- R1: The count tick fires once every `div_ratio`+1 clock cycles; with `div_ratio` = 0 both counters step on every cycle.
- R2: A write to index 4 or index 6 replaces only the low byte of the timer-1 latch. A write to index 7 replaces only the high latch byte and leaves the timer-1 counter untouched. Reads of index 6 and index 7 return the latch low and high bytes.
- R3: A write to index 5 stores the high latch byte and loads the timer-1 counter with {written byte, latch low byte} at that same edge; a load takes priority over a coincident tick. Index 4 reads the counter low byte and index 5 reads the counter high byte.
- R4: On each tick, timer 1 counts down through 0 to 0xFFFF, and on the next tick it reloads the latch, so every period after the first lasts latch+2 ticks.
- R5: `t1_set` pulses for one cycle, in the cycle the timer-1 counter first holds 0 after a tick, only when `aux_mode` (auxiliary-control bits 7:6) equals 2'b01. In any other mode the counter keeps running but `t1_set` stays low.
- R6: `t1_clr` is high while a read of index 4, a write of index 5 or a write of index 7 is presented; a read of index 5 does not raise it.
- R7: A write to index 8 stores the timer-2 low latch and loads the counter with {0x00, byte}. A write to index 9 loads the counter with {byte, stored low latch}. Index 8 and index 9 read the counter low and high bytes.
- R8: Timer 2 decrements on every tick and wraps at 16 bits. `t2_set` pulses once, when the counter first reaches 0 after a load. With no load since reset it never pulses.
- R9: `t2_clr` is high while a read of index 8 is presented; a write of index 8 does not raise it.
- R10: After reset, the timer-1 latch and counter read 0xFFFF, the timer-2 counter reads 0xFFFF, and the timer-2 low latch holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_ratio | input | DIV_W | Tick divider ratio; one tick every div_ratio+1 cycles |
| aux_mode | input | 2 | Auxiliary-control bits 7:6; 2'b01 selects the free-running mode |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (acknowledge side effects) |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Read data byte for indices 4..9, zero for other indices |
| t1_set | output | 1 | Timer-1 event set pulse |
| t1_clr | output | 1 | Timer-1 event clear pulse |
| t2_set | output | 1 | Timer-2 event set pulse |
| t2_clr | output | 1 | Timer-2 event clear pulse |

## Verification
The hardest case to reach is the reload step of timer 1: the single tick on which the counter holds 0xFFFF because it came down from zero, and not because it was loaded or reset to that value. The stimulus sets the divider to one tick per cycle, loads a small latch value, and then samples the counter and the set pulse on each following cycle, so that the 0xFFFF state, the reload and the latch+2 spacing all fall at exact known cycles. A second hard case is the never-armed timer 2 right after reset. To cover it, the bench runs a full 65,536-tick wrap before the first load and confirms that no set pulse appears.

// File: rtl/dit_pkg.sv
`timescale 1ns/1ps
package dit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] IDX_T1_CNT_LO = 4'd4;
  localparam logic [IDX_W-1:0] IDX_T1_CNT_HI = 4'd5;
  localparam logic [IDX_W-1:0] IDX_T1_LAT_LO = 4'd6;
  localparam logic [IDX_W-1:0] IDX_T1_LAT_HI = 4'd7;
  localparam logic [IDX_W-1:0] IDX_T2_LO     = 4'd8;
  localparam logic [IDX_W-1:0] IDX_T2_HI     = 4'd9;

  localparam logic [1:0] MODE_FREE_RUN = 2'b01;
endpackage

// File: rtl/dit_tick_gen.sv
`timescale 1ns/1ps
module dit_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div_ratio);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: after a tick the phase counter restarts from zero
  assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/dit_t1_core.sv
`timescale 1ns/1ps
module dit_t1_core
  import dit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              free_run,
  input  logic              wr,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  latch_o,
  output logic              set_o,
  output logic              clr_o
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, latch_q, latch_d;
  logic             uf_q, uf_d, set_q, set_d;
  logic             wr_lat_lo, wr_lat_hi, wr_load;

  assign wr_lat_lo = wr && (idx == IDX_T1_CNT_LO || idx == IDX_T1_LAT_LO);
  assign wr_lat_hi = wr && (idx == IDX_T1_LAT_HI);
  assign wr_load   = wr && (idx == IDX_T1_CNT_HI);

  always_comb begin
    latch_d = latch_q;
    if (wr_lat_lo)             latch_d[BYTE_W-1:0]     = wdata;
    if (wr_lat_hi || wr_load)  latch_d[CNT_W-1:BYTE_W] = wdata;
  end

  always_comb begin
    cnt_d = cnt_q;
    uf_d  = uf_q;
    set_d = 1'b0;
    if (wr_load) begin
      cnt_d = {wdata, latch_q[BYTE_W-1:0]};
      uf_d  = 1'b0;
    end else if (tick) begin
      if (uf_q) begin
        cnt_d = latch_q;
        uf_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
        uf_d  = (cnt_q == '0);
      end
      set_d = free_run && (cnt_d == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ONES;
      latch_q <= ONES;
      uf_q    <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
      uf_q    <= uf_d;
      set_q   <= set_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
  assign set_o   = set_q;
  assign clr_o   = wr_load || wr_lat_hi || (rd && idx == IDX_T1_CNT_LO);

  // R3: a load write places {data, latch low} into the counter
  assert_t1_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (cnt_q == {$past(wdata), $past(latch_q[BYTE_W-1:0])}));
  // R4: counting down from zero lands on all-ones with the reload pending
  assert_t1_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_load && !uf_q && cnt_q == '0) |=> (cnt_q == ONES && uf_q));
  // R4: the tick after the wrap reloads the latch
  assert_t1_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_load && uf_q) |=> (cnt_q == $past(latch_q)));
  // R5: a set pulse only with a zero counter and the free-running mode
  assert_t1_set_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |-> (cnt_q == '0 && $past(free_run)));
endmodule

// File: rtl/dit_t2_core.sv
`timescale 1ns/1ps
module dit_t2_core
  import dit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              set_o,
  output logic              clr_o
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] lat_q, lat_d;
  logic              armed_q, armed_d, set_q, set_d;
  logic              wr_lo, wr_hi;

  assign wr_lo = wr && (idx == IDX_T2_LO);
  assign wr_hi = wr && (idx == IDX_T2_HI);

  always_comb begin
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    armed_d = armed_q;
    set_d   = 1'b0;
    if (wr_lo) begin
      lat_d   = wdata;
      cnt_d   = {{BYTE_W{1'b0}}, wdata};
      armed_d = 1'b1;
    end else if (wr_hi) begin
      cnt_d   = {wdata, lat_q};
      armed_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q - ONE;
      if (armed_q && cnt_q == ONE) begin
        set_d   = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ONES;
      lat_q   <= '0;
      armed_q <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      armed_q <= armed_d;
      set_q   <= set_d;
    end
  end

  assign cnt_o = cnt_q;
  assign set_o = set_q;
  assign clr_o = rd && (idx == IDX_T2_LO);

  // R8: the pulse coincides with a zero counter and consumes the arming
  assert_t2_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |-> (cnt_q == '0 && !armed_q));
  // R7: any load arms the one-shot event
  assert_t2_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> armed_q);
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [1:0]        aux_mode,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  output logic              t1_set,
  output logic              t1_clr,
  output logic              t2_set,
  output logic              t2_clr
);
  logic             rst_meta_q, rst_sync_q;
  logic             tick;
  logic [CNT_W-1:0] t1_cnt, t1_lat, t2_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dit_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_q), .div_ratio(div_ratio), .tick(tick)
  );

  dit_t1_core u_t1 (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick),
    .free_run(aux_mode == MODE_FREE_RUN),
    .wr(acc_wr), .rd(acc_rd), .idx(acc_idx), .wdata(acc_wdata),
    .cnt_o(t1_cnt), .latch_o(t1_lat), .set_o(t1_set), .clr_o(t1_clr)
  );

  dit_t2_core u_t2 (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick),
    .wr(acc_wr), .rd(acc_rd), .idx(acc_idx), .wdata(acc_wdata),
    .cnt_o(t2_cnt), .set_o(t2_set), .clr_o(t2_clr)
  );

  always_comb begin
    case (acc_idx)
      IDX_T1_CNT_LO: acc_rdata = t1_cnt[BYTE_W-1:0];
      IDX_T1_CNT_HI: acc_rdata = t1_cnt[CNT_W-1:BYTE_W];
      IDX_T1_LAT_LO: acc_rdata = t1_lat[BYTE_W-1:0];
      IDX_T1_LAT_HI: acc_rdata = t1_lat[CNT_W-1:BYTE_W];
      IDX_T2_LO:     acc_rdata = t2_cnt[BYTE_W-1:0];
      IDX_T2_HI:     acc_rdata = t2_cnt[CNT_W-1:BYTE_W];
      default:       acc_rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_ratio;
  logic [1:0] aux_mode;
  logic       acc_wr, acc_rd;
  logic [3:0] acc_idx;
  logic [7:0] acc_wdata, acc_rdata;
  logic       t1_set, t1_clr, t2_set, t2_clr;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  dual_interval_timer #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .aux_mode(aux_mode),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .t1_set(t1_set), .t1_clr(t1_clr),
    .t2_set(t2_set), .t2_clr(t2_clr)
  );

  typedef struct packed {
    logic [3:0] widx;
    logic [7:0] wval;
    logic [3:0] pidx;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  // write, then read back through the register index at the next low phase
  localparam vec_t VECS [10] = '{
    '{4'd6, 8'h34, 4'd6, 8'h34, 8'd2},  // R2 latch low via index 6
    '{4'd7, 8'h12, 4'd7, 8'h12, 8'd2},  // R2 latch high via index 7
    '{4'd4, 8'h78, 4'd6, 8'h78, 8'd2},  // R2 latch low via index 4
    '{4'd5, 8'hAB, 4'd5, 8'hAB, 8'd3},  // R3 counter high after load
    '{4'd5, 8'h01, 4'd4, 8'h78, 8'd3},  // R3 counter low from latch
    '{4'd8, 8'h5A, 4'd8, 8'h5A, 8'd7},  // R7 timer-2 low load
    '{4'd8, 8'h5A, 4'd9, 8'h00, 8'd7},  // R7 high byte zero on low load
    '{4'd9, 8'hC3, 4'd9, 8'hC3, 8'd7},  // R7 high load
    '{4'd9, 8'h11, 4'd8, 8'h5A, 8'd7},  // R7 low byte from stored latch
    '{4'd7, 8'h99, 4'd6, 8'h78, 8'd2}   // R2 index 7 keeps latch low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = idx; acc_wdata = val;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [7:0] val);
    acc_idx = idx;
    #0.3;
    val = acc_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt1, cnt2, first, second;
    rst_n = 1'b0; div_ratio = 8'd200; aux_mode = 2'b00;
    acc_wr = 1'b0; acc_rd = 1'b0; acc_idx = 4'd0; acc_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset values
    peek(4'd4, v); check("R10 t1 cnt lo", v, 8'hFF);
    peek(4'd5, v); check("R10 t1 cnt hi", v, 8'hFF);
    peek(4'd6, v); check("R10 t1 lat lo", v, 8'hFF);
    peek(4'd7, v); check("R10 t1 lat hi", v, 8'hFF);
    peek(4'd8, v); check("R10 t2 cnt lo", v, 8'hFF);
    peek(4'd9, v); check("R10 t2 cnt hi", v, 8'hFF);

    // R8: unarmed timer 2 passes zero with no pulse; R5: mode 00 gives no t1 pulse
    div_ratio = 8'd0;
    cnt1 = 0; cnt2 = 0;
    for (int i = 0; i < 66000; i++) begin
      @(negedge clk);
      if (t1_set) cnt1++;
      if (t2_set) cnt2++;
    end
    check("R8 no pulse before load", cnt2, 0);
    check("R5 no pulse outside free-run", cnt1, 0);

    // R10 timer-2 low latch is zero after reset
    wr_reg(4'd9, 8'h00);
    peek(4'd8, v); check("R10 t2 latch lo", v, 8'h00);

    // vector table
    for (int k = 0; k < 10; k++) begin
      wr_reg(VECS[k].widx, VECS[k].wval);
      peek(VECS[k].pidx, v);
      n_checks++;
      if (v !== VECS[k].exp) begin
        n_errs++;
        $display("FAIL R%0d vector %0d: actual=%0h expected=%0h", VECS[k].req, k, v, VECS[k].exp);
      end
    end

    // R6 / R9 clear pulses, presented without a clock edge
    @(negedge clk);
    acc_rd = 1'b1; acc_idx = 4'd4; #0.3; check("R6 rd idx4 clears", t1_clr, 1);
    acc_idx = 4'd5;                #0.3; check("R6 rd idx5 no clear", t1_clr, 0);
    acc_idx = 4'd8;                #0.3; check("R9 rd idx8 clears", t2_clr, 1);
    acc_rd = 1'b0; acc_wr = 1'b1; acc_wdata = 8'h00;
    acc_idx = 4'd7;                #0.3; check("R6 wr idx7 clears", t1_clr, 1);
    acc_idx = 4'd5;                #0.3; check("R6 wr idx5 clears", t1_clr, 1);
    acc_idx = 4'd8;                #0.3; check("R9 wr idx8 no clear", t2_clr, 0);
    acc_wr = 1'b0; acc_idx = 4'd0;

    // R2: index 7 does not load the counter
    wr_reg(4'd6, 8'h10);
    wr_reg(4'd5, 8'h00);
    wr_reg(4'd7, 8'h80);
    peek(4'd4, v); check("R2 idx7 no load lo", v, 8'h0E);
    peek(4'd5, v); check("R2 idx7 no load hi", v, 8'h00);
    peek(4'd7, v); check("R2 idx7 latch hi", v, 8'h80);

    // R4 / R5 free-running period, latch = 3
    aux_mode = 2'b01;
    wr_reg(4'd6, 8'h03);
    wr_reg(4'd5, 8'h00);
    cnt1 = 0; first = 0; second = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (t1_set) begin
        cnt1++;
        if (first == 0) first = i; else if (second == 0) second = i;
      end
      if (i == 4) begin
        peek(4'd5, v); check("R4 passes 0xFFFF hi", v, 8'hFF);
        peek(4'd4, v); check("R4 passes 0xFFFF lo", v, 8'hFF);
      end
      if (i == 5) begin
        peek(4'd4, v); check("R4 reload from latch", v, 8'h03);
      end
    end
    check("R5 first pulse at zero", first, 3);
    check("R4 period latch+2", second - first, 5);
    check("R4 pulse count", cnt1, 2);

    // R5 gating in mode 00
    aux_mode = 2'b00;
    wr_reg(4'd5, 8'h00);
    cnt1 = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (t1_set) cnt1++;
    end
    check("R5 mode 00 silent", cnt1, 0);

    // R1 divider: latch 1, period 3 ticks = 15 cycles at ratio 4
    aux_mode = 2'b01;
    div_ratio = 8'd4;
    wr_reg(4'd6, 8'h01);
    wr_reg(4'd5, 8'h00);
    first = 0; second = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (t1_set) begin
        if (first == 0) first = i; else if (second == 0) second = i;
      end
    end
    check("R1 tick spacing", second - first, 15);

    // R8 one-shot timer 2
    aux_mode = 2'b00;
    div_ratio = 8'd0;
    wr_reg(4'd8, 8'h03);
    wr_reg(4'd9, 8'h00);
    cnt2 = 0; first = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (t2_set) begin
        cnt2++;
        if (first == 0) first = i;
      end
    end
    check("R8 t2 pulse time", first, 3);
    check("R8 t2 single pulse", cnt2, 1);
    peek(4'd9, v); check("R8 t2 wraps", v, 8'hFF);

    // R8 re-arm on a new load
    wr_reg(4'd9, 8'h00);
    cnt2 = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (t2_set) cnt2++;
    end
    check("R8 t2 rearmed", cnt2, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule